// File: doc/BRIEF.md
# Idle Retention Entry Timer

This block decides when two power domains, a processor core and its SIMD/floating-point unit, may enter retention. Each domain has its own delay channel. A channel counts single-cycle pulses from an external slow timer while its domain reports idle. When the programmed number of pulses has been seen, the channel raises a retention-entry request. The request stays high until the domain leaves idle.

Software programs both channels through one 64-bit control word. The word is written and read in a single access, carried as a low and a high 32-bit half. The same word holds a cluster-coherency enable bit, which the block drives out unchanged. Each channel has a 3-bit delay code. Code zero turns the channel off. The other codes select a non-linear delay of 2 to 512 ticks. A parameter states whether the floating-point unit exists. When it does not, that unit's field and request stay at zero.

Top module: `idle_ret_timer`

## Requirements
- R1: While `rst_n` is low, the control word reads zero, both requests are low and `coh_en` is low, and this holds from the moment reset asserts. Reset assertion is asynchronous, release is synchronised inside the block, and both counters return to zero.
- R2: Bits 63..7 of the control word (all of `rd_hi`, and `rd_lo[31:7]`) always read zero, whatever was written to them.
- R3: Bit 6 of the control word is the coherency enable. `coh_en` follows the stored bit and changes only on a write.
- R4: Bits 2..0 hold the core delay code and bits 5..3 hold the floating-point delay code. Codes 1 to 7 select 2, 8, 32, 64, 128, 256 and 512 ticks. The request is first seen high in the cycle after the clock edge that samples the last required tick.
- R5: A channel whose code is 0 never raises its request, however many ticks arrive while it is idle.
- R6: A channel counts only on cycles where `tick` is high and its idle input is high. If the idle input is low at a clock edge, the count returns to zero and the request is low from the next cycle.
- R7: Once raised, a request stays high while idle stays high and no write changes the code. Further ticks saturate the count and never wrap it.
- R8: A write that changes a channel's code clears that channel's count and request, so the new delay is counted from zero. A write that leaves the code unchanged does not disturb the count.
- R9: The two channels are independent. Ticks, idle and code on one channel never affect the other channel's request.
- R10: With `FP_PRESENT` = 0, bits 5..3 read zero whatever is written to them, and `fp_ret_req` stays low.
- R11: One write with `wr_en` high loads both halves at once from `wr_lo` and `wr_hi`. `rd_lo` and `rd_hi` show the stored word in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole 64-bit word |
| wr_lo | input | 32 | Write data, bits 31..0 |
| wr_hi | input | 32 | Write data, bits 63..32 |
| rd_lo | output | 32 | Read data, bits 31..0 |
| rd_hi | output | 32 | Read data, bits 63..32 |
| tick | input | 1 | Slow-timer pulse, one cycle wide |
| core_idle | input | 1 | Core domain reports idle |
| fp_idle | input | 1 | Floating-point domain reports idle |
| core_ret_req | output | 1 | Core retention-entry request |
| fp_ret_req | output | 1 | Floating-point retention-entry request |
| coh_en | output | 1 | Cluster coherency enable |

## Verification
The assertions check the following on every cycle:
- the reserved bits read as zero;
- a request falls after idle drops;
- a request only rises right after a tick;
- a raised request holds while nothing disturbs it;
- code zero keeps a request low;
- the coherency bit changes only on a write;
- with no floating-point unit, its field and request stay at zero.

Some behaviour needs the bench's scenarios:
- the exact tick count for each of the seven codes;
- saturation past the 10-bit range;
- clearing on a code change, and no clearing on a rewrite of the same code;
- asynchronous reset during an active request.

A random phase, run against a bench model, mixes writes, idle changes and ticks on both channels.

// File: rtl/ret_pkg.sv
package ret_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned MAX_LOG2 = 9;            // longest delay is 2**9 ticks
  localparam int unsigned CNT_W    = MAX_LOG2 + 1;
  localparam int unsigned CTL_W    = 7;            // implemented control bits

  // Non-linear code to tick-count mapping; 0 means disabled.
  function automatic logic [CNT_W-1:0] code_limit(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    case (code)
      3'd0:    code_limit = '0;
      3'd1:    code_limit = one << 1;
      3'd2:    code_limit = one << 3;
      default: code_limit = one << (32'(code) + 2);
    endcase
  endfunction
endpackage

// File: rtl/ret_ctrl_reg.sv
module ret_ctrl_reg
  import ret_pkg::*;
#(
  parameter bit FP_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_lo,
  input  logic [31:0]       wr_hi,
  output logic [31:0]       rd_lo,
  output logic [31:0]       rd_hi,
  output logic [CODE_W-1:0] core_code,
  output logic [CODE_W-1:0] fp_code,
  output logic              core_chg,
  output logic              fp_chg,
  output logic              coh_bit
);
  localparam logic [CTL_W-1:0] WR_MASK = FP_PRESENT ? 7'h7F : 7'h47;

  logic [CTL_W-1:0] ctl_q, ctl_d, wr_val;
  logic [31:0]      hi_ignored;

  assign hi_ignored = wr_hi;            // upper half is accepted but never stored
  assign wr_val     = wr_lo[CTL_W-1:0] & WR_MASK;

  always_comb begin
    ctl_d    = ctl_q;
    core_chg = 1'b0;
    fp_chg   = 1'b0;
    if (wr_en) begin
      ctl_d    = wr_val;
      core_chg = (wr_val[2:0] != ctl_q[2:0]);
      fp_chg   = (wr_val[5:3] != ctl_q[5:3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  assign core_code = ctl_q[2:0];
  assign fp_code   = ctl_q[5:3];
  assign coh_bit   = ctl_q[6];
  assign rd_lo     = {{(32-CTL_W){1'b0}}, ctl_q};
  assign rd_hi     = hi_ignored & 32'h0;
endmodule

// File: rtl/ret_channel.sv
module ret_channel
  import ret_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              clr,
  input  logic              idle,
  input  logic              tick,
  output logic              req
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  assign limit = code_limit(code);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !idle || code == '0) begin
      cnt_d = '0;
    end else if (tick && cnt_q < limit) begin
      cnt_d = cnt_q + 1'b1;
    end
    req_d = (code != '0) && !clr && idle && (cnt_d >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/idle_ret_timer.sv
module idle_ret_timer
  import ret_pkg::*;
#(
  parameter bit FP_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_lo,
  input  logic [31:0] wr_hi,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi,
  input  logic        tick,
  input  logic        core_idle,
  input  logic        fp_idle,
  output logic        core_ret_req,
  output logic        fp_ret_req,
  output logic        coh_en
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [CODE_W-1:0] core_code, fp_code;
  logic              core_chg, fp_chg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ret_ctrl_reg #(.FP_PRESENT(FP_PRESENT)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .core_code(core_code), .fp_code(fp_code),
    .core_chg(core_chg), .fp_chg(fp_chg), .coh_bit(coh_en)
  );

  ret_channel u_core (
    .clk(clk), .rst_n(rst_int_n), .code(core_code), .clr(core_chg),
    .idle(core_idle), .tick(tick), .req(core_ret_req)
  );

  generate
    if (FP_PRESENT) begin : g_fp
      ret_channel u_fp (
        .clk(clk), .rst_n(rst_int_n), .code(fp_code), .clr(fp_chg),
        .idle(fp_idle), .tick(tick), .req(fp_ret_req)
      );
    end else begin : g_no_fp
      logic fp_unused;
      assign fp_unused  = fp_idle & fp_chg & (|fp_code);
      assign fp_ret_req = fp_unused & 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ret_timer_chk.sv
module ret_timer_chk #(
  parameter bit FP_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] rd_lo,
  input logic [31:0] rd_hi,
  input logic        tick,
  input logic        core_idle,
  input logic        fp_idle,
  input logic        core_ret_req,
  input logic        fp_ret_req,
  input logic        coh_en
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi == 32'h0 && rd_lo[31:7] == 25'h0));

  assert_coh_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(coh_en));

  assert_core_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ret_req) |-> $past(tick));

  assert_fp_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fp_ret_req) |-> $past(tick));

  assert_core_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo[2:0] == 3'd0) |=> !core_ret_req);

  assert_fp_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo[5:3] == 3'd0) |=> !fp_ret_req);

  assert_core_idle_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> !core_ret_req);

  assert_fp_idle_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_idle |=> !fp_ret_req);

  assert_core_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ret_req && core_idle && !wr_en) |=> core_ret_req);

  assert_fp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_ret_req && fp_idle && !wr_en) |=> fp_ret_req);

  assert_fp_absent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !FP_PRESENT |-> (rd_lo[5:3] == 3'd0 && !fp_ret_req));
endmodule

bind idle_ret_timer ret_timer_chk #(.FP_PRESENT(FP_PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .tick(tick), .core_idle(core_idle), .fp_idle(fp_idle),
  .core_ret_req(core_ret_req), .fp_ret_req(fp_ret_req), .coh_en(coh_en)
);

// File: tb/idle_ret_timer_test.sv
`timescale 1ns/1ps
module idle_ret_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_lo = '0, wr_hi = '0;
  logic        tick = 1'b0, core_idle = 1'b0, fp_idle = 1'b0;
  logic [31:0] rd_lo, rd_hi, rd_lo2, rd_hi2;
  logic        core_ret_req, fp_ret_req, coh_en;
  logic        core_ret_req2, fp_ret_req2, coh_en2;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  idle_ret_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .tick(tick), .core_idle(core_idle),
    .fp_idle(fp_idle), .core_ret_req(core_ret_req), .fp_ret_req(fp_ret_req),
    .coh_en(coh_en)
  );

  idle_ret_timer #(.FP_PRESENT(1'b0)) uut_nofp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo2), .rd_hi(rd_hi2), .tick(tick), .core_idle(core_idle),
    .fp_idle(fp_idle), .core_ret_req(core_ret_req2), .fp_ret_req(fp_ret_req2),
    .coh_en(coh_en2)
  );

  // Delay table from R4.
  function automatic int ticks_for(input int code);
    case (code)
      1: return 2;    2: return 8;    3: return 32;   4: return 64;
      5: return 128;  6: return 256;  7: return 512;
      default: return 0;
    endcase
  endfunction

  // Bench model of the full-featured instance, from R4..R9.
  int   m_code[2], m_cnt[2];
  bit   m_req[2];
  bit   m_coh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_code[i] = 0; m_cnt[i] = 0; m_req[i] = 0; end
      m_coh = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        int  nc;
        bit  chg, idl;
        nc  = (i == 0) ? int'(wr_lo[2:0]) : int'(wr_lo[5:3]);
        chg = wr_en && (nc != m_code[i]);
        idl = (i == 0) ? core_idle : fp_idle;
        if (chg || !idl || m_code[i] == 0) m_cnt[i] = 0;
        else if (tick && m_cnt[i] < ticks_for(m_code[i])) m_cnt[i]++;
        m_req[i] = !chg && idl && m_code[i] != 0 && m_cnt[i] >= ticks_for(m_code[i]);
        if (wr_en) m_code[i] = nc;
      end
      if (wr_en) m_coh = wr_lo[6];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [31:0] lo, input logic [31:0] hi);
    wr_en = 1'b1; wr_lo = lo; wr_hi = hi;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1; cyc();
      tick = 1'b0; cyc();
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    $urandom(32'd2718);
    cyc(3);
    // R1 reset state
    check("R1 rd_lo in reset", rd_lo, 0);
    check("R1 reqs in reset", {core_ret_req, fp_ret_req, coh_en}, 0);
    rst_n = 1'b1;
    cyc(4);
    check("R1 rd after release", {rd_hi, rd_lo}, 0);

    // R2, R3, R11: write everything ones
    write(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 rd_hi reserved", rd_hi, 0);
    check("R11 rd_lo stored", rd_lo, 32'h7F);
    check("R3 coh_en set", coh_en, 1);
    check("R10 nofp field masked", rd_lo2, 32'h47);
    write(32'h0000_0000, 32'hA5A5_A5A5);
    check("R3 coh_en cleared", coh_en, 0);
    check("R2 rd_hi after write", rd_hi, 0);

    // R4: each code on the core channel
    core_idle = 1'b1;
    for (int c = 1; c <= 7; c++) begin
      write(32'(c), 0);
      ticks(ticks_for(c) - 1);
      check($sformatf("R4 code %0d one tick short", c), core_ret_req, 0);
      ticks(1);
      check($sformatf("R4 code %0d reached", c), core_ret_req, 1);
      check("R9 fp untouched", fp_ret_req, 0);
      core_idle = 1'b0; cyc(); core_idle = 1'b1;
    end
    // R4: fp field position
    write(32'h08, 0);      // fp code 1, core code 0
    fp_idle = 1'b1;
    ticks(1);
    check("R4 fp one short", fp_ret_req, 0);
    ticks(1);
    check("R4 fp code 1 reached", fp_ret_req, 1);
    check("R5 core code 0 no req", core_ret_req, 0);
    check("R10 nofp req low", fp_ret_req2, 0);

    // R5: code 0 with many ticks
    ticks(600);
    check("R5 code 0 after 600 ticks", core_ret_req, 0);

    // R7: saturation past the 10-bit range
    write(32'h01, 0);
    ticks(1100);
    check("R7 saturate no wrap", core_ret_req, 1);

    // R6: idle drop clears the count
    write(32'h02, 0);
    ticks(5);
    core_idle = 1'b0; cyc(); core_idle = 1'b1;
    check("R6 req low after idle drop", core_ret_req, 0);
    ticks(5);
    check("R6 count restarted", core_ret_req, 0);
    ticks(3);
    check("R6 reached after restart", core_ret_req, 1);
    tick = 1'b0; core_idle = 1'b1;
    cyc(3);
    check("R6 no tick no change", core_ret_req, 1);

    // R8: code change clears; same code keeps
    write(32'h01, 0); write(32'h02, 0);
    ticks(7);
    write(32'h03, 0);
    ticks(1);
    check("R8 changed code restarts", core_ret_req, 0);
    write(32'h02, 0);
    ticks(7);
    write(32'h02, 0);
    ticks(1);
    check("R8 same code keeps count", core_ret_req, 1);

    // R9: channels independent
    write(32'h0F, 0);      // core 7, fp 1
    ticks(2);
    check("R9 fp reached alone", fp_ret_req, 1);
    check("R9 core still counting", core_ret_req, 0);
    fp_idle = 1'b0; cyc();
    check("R9 fp drop", fp_ret_req, 0);

    // R1: asynchronous reset during an active request
    write(32'h41, 0); ticks(2);
    check("R1 pre-reset req", core_ret_req, 1);
    #3 rst_n = 1'b0; #1;
    check("R1 async clear req", core_ret_req, 0);
    check("R1 async clear word", rd_lo, 0);
    cyc(2); rst_n = 1'b1; core_idle = 1'b0; cyc(4);

    // Random phase against the model (R6, R7, R8, R9)
    for (int k = 0; k < 6000; k++) begin
      wr_en     = ($urandom_range(0, 40) == 0);
      wr_lo     = {$urandom} & 32'h0000_00DB;   // codes up to 3 per channel
      wr_hi     = $urandom;
      tick      = ($urandom_range(0, 2) == 0);
      core_idle = ($urandom_range(0, 60) != 0);
      fp_idle   = ($urandom_range(0, 60) != 0);
      cyc();
      check("R6/R7 random core", core_ret_req, m_req[0]);
      check("R8/R9 random fp", fp_ret_req, m_req[1]);
      check("R3 random coh", coh_en, m_coh);
    end
    wr_en = 1'b0;
    finish_run();
  end
endmodule